// File: doc/BRIEF.md
# Serial Clock-Chip Bring-Up and Time Access Sequencer

This block drives a real-time-clock chip over a two-wire bus. It does so through a byte-level bus master that accepts one command at a time: start, write byte, read byte or stop. After reset it checks the chip's two status registers and repairs them where needed. It first clears the power-loss condition by setting 24-hour mode and the reset bit. It then takes the chip out of test mode. Once this is done it raises `ready` and serves host requests that read or write the seven-byte calendar block.

The chip has no register index byte. The register is chosen by a 3-bit command field inside the address byte. The chip also sees every data byte with its bits mirrored. The sequencer builds each address byte from the fixed device code, the command and the direction bit. It mirrors each data byte on the way out and on the way back, so the host sees plain values. A failed bus command ends the running sequence at once. Initialization then halts for good, and a host request completes with an error flag.

Top module: `rtc_seq_top`

## Requirements
- R1: Every address byte is {4'b0110, command[2:0], dir}, with dir = 1 for reads. Status1 uses command 0, status2 uses command 1 and the calendar block uses command 2, so the address bytes are 0x61/0x60, 0x63/0x62 and 0x65/0x64.
- R2: Each data byte written to the bus is the bit mirror (bit i to bit 7-i) of the host-side value. Each byte read from the bus is mirrored back before use.
- R3: After reset the sequencer reads status1. If bit 7 or bit 6 of the value is set, it writes status1 back with bits 1 and 0 also set. Otherwise it issues no write to status1.
- R4: The sequencer then reads status2. If bit 7 is set, it writes status2 back with bit 7 cleared and the other bits kept. Otherwise it issues no write.
- R5: `ready` rises only when initialization completes without error, and stays high until reset. Before that, `busy` is high and a held `host_req` is not accepted.
- R6: A get request (`host_op` = 0) reads seven bytes with command 2. The bytes are year, month, day, weekday, hour, minute and second, placed on `host_rtime` from bits 55:48 down to bits 7:0.
- R7: On a get, the hour byte is reduced to its low 6 bits and the weekday byte to its low 3 bits.
- R8: A set request (`host_op` = 1) writes the seven bytes of `host_wtime` with command 2, in the same order and packing as R6, without masking.
- R9: Every read byte except the last of a transfer is issued with `cmd_nack` = 0. The last is issued with `cmd_nack` = 1.
- R10: A missing ack on an address byte or a written byte, or `cmd_err` on any command, makes the next command a stop, with no further byte. During initialization this sets `init_fail` and leaves `ready` low for good. On a host request it completes with `host_err` = 1.
- R11: A command is presented on `cmd_valid`/`cmd_kind` (0 start, 1 write, 2 read, 3 stop) and held stable until the cycle `cmd_done` is high.
- R12: `host_ack` is a one-cycle pulse that ends each accepted request. `host_err` and `host_rtime` are valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host request, held until `host_ack` |
| host_op | input | 1 | 0 = get time, 1 = set time |
| host_wtime | input | 56 | Calendar bytes to write, year in the top byte |
| host_ack | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Request failed on the bus |
| host_rtime | output | 56 | Calendar bytes read, masked per R7 |
| busy | output | 1 | Not accepting requests |
| ready | output | 1 | Initialization succeeded |
| init_fail | output | 1 | Initialization aborted on a bus failure |
| cmd_valid | output | 1 | Bus command presented |
| cmd_kind | output | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmd_wdata | output | 8 | Byte to write (address or mirrored data) |
| cmd_nack | output | 1 | Answer this read with NACK |
| cmd_done | input | 1 | Current command finished |
| cmd_ack | input | 1 | Slave acknowledged the written byte |
| cmd_err | input | 1 | Bus-level failure of the command |
| cmd_rdata | input | 8 | Byte received by a read |

## Verification
Every cycle, the assertions check the following. A command stays stable while it waits for completion (R11). The NACK flag appears only on reads (R9). `ready` is sticky and excludes `init_fail` (R5, R10). `ready` rises only with the bus idle. `host_ack` is a single pulse (R12). Only the bench's scenarios can show the data path: address composition, bit mirroring, the conditional status writes, calendar ordering and masking, and the exact command sequence at an abort. The bench replays the chip's register file and checks every command against an expected stream. It injects a missing ack or a bus error at a chosen command.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;
  typedef enum logic [1:0] {
    CK_START = 2'd0,
    CK_WRITE = 2'd1,
    CK_READ  = 2'd2,
    CK_STOP  = 2'd3
  } cmd_kind_e;

  localparam logic [3:0] DEV_CODE  = 4'b0110;
  localparam logic [2:0] SEL_STAT1 = 3'd0;
  localparam logic [2:0] SEL_STAT2 = 3'd1;
  localparam logic [2:0] SEL_CAL   = 3'd2;

  localparam int CAL_BYTES = 7;
  localparam int HOUR_POS  = 4;
  localparam int WDAY_POS  = 3;

  localparam logic [7:0] S1_NEEDS_INIT = 8'hC0;
  localparam logic [7:0] S1_INIT_SET   = 8'h03;
  localparam logic [7:0] S2_TEST_BIT   = 8'h80;
endpackage

// File: rtl/rtc_bit_mirror.sv
module rtc_bit_mirror #(
  parameter int W = 8
) (
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q[i] = d[W-1-i];
  end
endmodule

// File: rtl/rtc_seq_xfer.sv
module rtc_seq_xfer
  import rtc_seq_pkg::*;
#(
  parameter int NB = CAL_BYTES,
  localparam int BW = 8 * NB,
  localparam int LW = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x_start,
  input  logic [2:0]    x_cmd,
  input  logic          x_rd,
  input  logic [LW-1:0] x_len,
  input  logic [BW-1:0] x_wbuf,
  output logic          x_done,
  output logic          x_err,
  output logic [BW-1:0] x_rbuf,
  output logic          cmd_valid,
  output cmd_kind_e     cmd_kind,
  output logic [7:0]    cmd_wdata,
  output logic          cmd_nack,
  input  logic          cmd_done,
  input  logic          cmd_ack,
  input  logic          cmd_err,
  input  logic [7:0]    cmd_rdata
);
  typedef enum logic [2:0] {X_IDLE, X_START, X_ADDR, X_DATA, X_STOP} xst_e;

  xst_e          st_q, st_d;
  logic [2:0]    sel_q, sel_d;
  logic          rd_q, rd_d;
  logic [LW-1:0] left_q, left_d;
  logic [BW-1:0] sh_q, sh_d;
  logic          fail_q, fail_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic [7:0]    rd_mir, wr_mir;

  rtc_bit_mirror #(.W(8)) u_rd_mirror (.d(cmd_rdata), .q(rd_mir));
  rtc_bit_mirror #(.W(8)) u_wr_mirror (.d(sh_q[BW-1 -: 8]), .q(wr_mir));

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    rd_d   = rd_q;
    left_d = left_q;
    sh_d   = sh_q;
    fail_d = fail_q;
    done_d = 1'b0;
    err_d  = err_q;
    case (st_q)
      X_IDLE: if (x_start) begin
        sel_d  = x_cmd;
        rd_d   = x_rd;
        left_d = x_len;
        sh_d   = x_wbuf;
        fail_d = 1'b0;
        st_d   = X_START;
      end
      X_START: if (cmd_done) begin
        if (cmd_err) begin
          fail_d = 1'b1;
          st_d   = X_STOP;
        end else begin
          st_d = X_ADDR;
        end
      end
      X_ADDR: if (cmd_done) begin
        if (cmd_err || !cmd_ack) begin
          fail_d = 1'b1;
          st_d   = X_STOP;
        end else if (left_q == '0) begin
          st_d = X_STOP;
        end else begin
          st_d = X_DATA;
        end
      end
      X_DATA: if (cmd_done) begin
        if (cmd_err || (!rd_q && !cmd_ack)) begin
          fail_d = 1'b1;
          st_d   = X_STOP;
        end else begin
          sh_d   = rd_q ? {sh_q[BW-9:0], rd_mir} : {sh_q[BW-9:0], 8'h00};
          left_d = left_q - LW'(1);
          if (left_q == LW'(1)) st_d = X_STOP;
        end
      end
      X_STOP: if (cmd_done) begin
        done_d = 1'b1;
        err_d  = fail_q | cmd_err;
        st_d   = X_IDLE;
      end
      default: st_d = X_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= X_IDLE;
      sel_q  <= '0;
      rd_q   <= 1'b0;
      left_q <= '0;
      sh_q   <= '0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      rd_q   <= rd_d;
      left_q <= left_d;
      sh_q   <= sh_d;
      fail_q <= fail_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    case (st_q)
      X_START: cmd_kind = CK_START;
      X_ADDR:  cmd_kind = CK_WRITE;
      X_DATA:  cmd_kind = rd_q ? CK_READ : CK_WRITE;
      default: cmd_kind = CK_STOP;
    endcase
  end

  assign cmd_valid = (st_q != X_IDLE);
  assign cmd_wdata = (st_q == X_ADDR) ? {DEV_CODE, sel_q, rd_q} : wr_mir;
  assign cmd_nack  = (st_q == X_DATA) && rd_q && (left_q == LW'(1));
  assign x_done    = done_q;
  assign x_err     = err_q;
  assign x_rbuf    = sh_q;

  // R11: a presented command does not change until it completes
  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=>
      (cmd_valid && $stable(cmd_kind) && $stable(cmd_wdata) && $stable(cmd_nack)));

  // R9: the NACK request only accompanies a read
  a_r9_nack_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_nack |-> (cmd_valid && cmd_kind == CK_READ));

  // R10: a finished transfer leaves the bus idle
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    x_done |-> !cmd_valid);
endmodule

// File: rtl/rtc_seq_ctrl.sv
module rtc_seq_ctrl
  import rtc_seq_pkg::*;
#(
  parameter int NB = CAL_BYTES,
  localparam int BW = 8 * NB,
  localparam int LW = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_op,
  input  logic [BW-1:0] host_wtime,
  output logic          host_ack,
  output logic          host_err,
  output logic [BW-1:0] host_rtime,
  output logic          busy,
  output logic          ready,
  output logic          init_fail,
  output logic          x_start,
  output logic [2:0]    x_cmd,
  output logic          x_rd,
  output logic [LW-1:0] x_len,
  output logic [BW-1:0] x_wbuf,
  input  logic          x_done,
  input  logic          x_err,
  input  logic [BW-1:0] x_rbuf
);
  typedef enum logic [3:0] {
    C_RD1, C_W_RD1, C_WR1, C_W_WR1,
    C_RD2, C_W_RD2, C_WR2, C_W_WR2,
    C_READY, C_HOST, C_W_HOST, C_FAIL
  } cst_e;

  function automatic logic [BW-1:0] mk_mask();
    logic [BW-1:0] m;
    m = '1;
    m[8*(NB-1-HOUR_POS) +: 8] = 8'h3F;
    m[8*(NB-1-WDAY_POS) +: 8] = 8'h07;
    return m;
  endfunction

  localparam logic [BW-1:0] RD_MASK = mk_mask();

  cst_e          st_q, st_d;
  logic [7:0]    stat_q, stat_d;
  logic          op_q, op_d;
  logic [BW-1:0] time_q, time_d;
  logic          ack_q, ack_d;
  logic          herr_q, herr_d;
  logic          rdy_q, rdy_d;
  logic [7:0]    one_byte;

  always_comb begin
    st_d     = st_q;
    stat_d   = stat_q;
    op_d     = op_q;
    time_d   = time_q;
    ack_d    = 1'b0;
    herr_d   = herr_q;
    rdy_d    = rdy_q;
    x_start  = 1'b0;
    x_cmd    = SEL_STAT1;
    x_rd     = 1'b1;
    x_len    = LW'(1);
    one_byte = 8'h00;
    x_wbuf   = '0;
    case (st_q)
      C_RD1: begin
        x_start = 1'b1;
        st_d    = C_W_RD1;
      end
      C_W_RD1: if (x_done) begin
        stat_d = x_rbuf[7:0];
        if (x_err)                                  st_d = C_FAIL;
        else if ((x_rbuf[7:0] & S1_NEEDS_INIT) != 0) st_d = C_WR1;
        else                                        st_d = C_RD2;
      end
      C_WR1: begin
        x_start  = 1'b1;
        x_rd     = 1'b0;
        one_byte = stat_q | S1_INIT_SET;
        x_wbuf   = {one_byte, {(BW-8){1'b0}}};
        st_d     = C_W_WR1;
      end
      C_W_WR1: if (x_done) st_d = x_err ? C_FAIL : C_RD2;
      C_RD2: begin
        x_start = 1'b1;
        x_cmd   = SEL_STAT2;
        st_d    = C_W_RD2;
      end
      C_W_RD2: if (x_done) begin
        stat_d = x_rbuf[7:0];
        if (x_err)                                st_d = C_FAIL;
        else if ((x_rbuf[7:0] & S2_TEST_BIT) != 0) st_d = C_WR2;
        else begin
          st_d  = C_READY;
          rdy_d = 1'b1;
        end
      end
      C_WR2: begin
        x_start  = 1'b1;
        x_cmd    = SEL_STAT2;
        x_rd     = 1'b0;
        one_byte = stat_q & ~S2_TEST_BIT;
        x_wbuf   = {one_byte, {(BW-8){1'b0}}};
        st_d     = C_W_WR2;
      end
      C_W_WR2: if (x_done) begin
        if (x_err) st_d = C_FAIL;
        else begin
          st_d  = C_READY;
          rdy_d = 1'b1;
        end
      end
      C_READY: if (host_req) begin
        op_d   = host_op;
        time_d = host_wtime;
        st_d   = C_HOST;
      end
      C_HOST: begin
        x_start = 1'b1;
        x_cmd   = SEL_CAL;
        x_rd    = !op_q;
        x_len   = LW'(NB);
        x_wbuf  = time_q;
        st_d    = C_W_HOST;
      end
      C_W_HOST: if (x_done) begin
        ack_d  = 1'b1;
        herr_d = x_err;
        if (!op_q && !x_err) time_d = x_rbuf & RD_MASK;
        st_d = C_READY;
      end
      default: st_d = C_FAIL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= C_RD1;
      stat_q <= '0;
      op_q   <= 1'b0;
      time_q <= '0;
      ack_q  <= 1'b0;
      herr_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      stat_q <= stat_d;
      op_q   <= op_d;
      time_q <= time_d;
      ack_q  <= ack_d;
      herr_q <= herr_d;
      rdy_q  <= rdy_d;
    end
  end

  assign host_ack   = ack_q;
  assign host_err   = herr_q;
  assign host_rtime = time_q;
  assign busy       = (st_q != C_READY);
  assign ready      = rdy_q;
  assign init_fail  = (st_q == C_FAIL);

  // R5: requests are refused until initialization has succeeded
  a_r5_busy_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> busy);

  // R5: ready never drops once raised
  a_r5_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R10: a failed bring-up never reports ready
  a_r10_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && init_fail));

  // R12: completion is a single-cycle pulse
  a_r12_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);
endmodule

// File: rtl/rtc_seq_top.sv
module rtc_seq_top
  import rtc_seq_pkg::*;
#(
  parameter int NB = CAL_BYTES,
  localparam int BW = 8 * NB,
  localparam int LW = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_op,
  input  logic [BW-1:0] host_wtime,
  output logic          host_ack,
  output logic          host_err,
  output logic [BW-1:0] host_rtime,
  output logic          busy,
  output logic          ready,
  output logic          init_fail,
  output logic          cmd_valid,
  output logic [1:0]    cmd_kind,
  output logic [7:0]    cmd_wdata,
  output logic          cmd_nack,
  input  logic          cmd_done,
  input  logic          cmd_ack,
  input  logic          cmd_err,
  input  logic [7:0]    cmd_rdata
);
  logic          x_start, x_rd, x_done, x_err;
  logic [2:0]    x_cmd;
  logic [LW-1:0] x_len;
  logic [BW-1:0] x_wbuf, x_rbuf;
  cmd_kind_e     kind_int;

  rtc_seq_ctrl #(.NB(NB)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_op(host_op), .host_wtime(host_wtime),
    .host_ack(host_ack), .host_err(host_err), .host_rtime(host_rtime),
    .busy(busy), .ready(ready), .init_fail(init_fail),
    .x_start(x_start), .x_cmd(x_cmd), .x_rd(x_rd), .x_len(x_len),
    .x_wbuf(x_wbuf), .x_done(x_done), .x_err(x_err), .x_rbuf(x_rbuf)
  );

  rtc_seq_xfer #(.NB(NB)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .x_start(x_start), .x_cmd(x_cmd), .x_rd(x_rd), .x_len(x_len),
    .x_wbuf(x_wbuf), .x_done(x_done), .x_err(x_err), .x_rbuf(x_rbuf),
    .cmd_valid(cmd_valid), .cmd_kind(kind_int), .cmd_wdata(cmd_wdata),
    .cmd_nack(cmd_nack), .cmd_done(cmd_done), .cmd_ack(cmd_ack),
    .cmd_err(cmd_err), .cmd_rdata(cmd_rdata)
  );

  assign cmd_kind = kind_int;

  // R5: ready appears only after the last bring-up transfer has released the bus
  a_r5_ready_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> !cmd_valid);
endmodule

// File: tb/rtc_seq_top_bench.sv
module rtc_seq_top_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, host_req, host_op, host_ack, host_err, busy, ready, init_fail;
  logic [55:0] host_wtime, host_rtime;
  logic        cmd_valid, cmd_nack, cmd_done, cmd_ack, cmd_err;
  logic [1:0]  cmd_kind;
  logic [7:0]  cmd_wdata, cmd_rdata;

  rtc_seq_top u_rtc_seq_top (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_op(host_op),
    .host_wtime(host_wtime), .host_ack(host_ack), .host_err(host_err),
    .host_rtime(host_rtime), .busy(busy), .ready(ready), .init_fail(init_fail),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_wdata(cmd_wdata),
    .cmd_nack(cmd_nack), .cmd_done(cmd_done), .cmd_ack(cmd_ack),
    .cmd_err(cmd_err), .cmd_rdata(cmd_rdata)
  );

  int nvec = 0;
  int nerr = 0;
  int cyc  = 0;

  int         qk[$];
  logic [7:0] qd[$];
  bit         qn[$];

  logic [7:0] mem [8][7];
  int         cmd_no, fault_at, cidx, mcnt;
  bit         fault_err, mbusy, ack_allowed;
  logic [2:0] csel;
  logic [1:0] mk;
  logic [7:0] md;
  bit         mn;

  localparam logic [55:0] MASKB = 56'hFF_FF_FF_07_3F_FF_FF;
  localparam logic [55:0] T1    = 56'h25_12_31_FD_E3_59_47;
  localparam logic [55:0] T2    = 56'h99_88_77_66_55_44_33;

  function automatic logic [7:0] mir(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic exp_cmd(input int k, input logic [7:0] d, input bit n);
    qk.push_back(k);
    qd.push_back(d);
    qn.push_back(n);
  endtask

  task automatic exp_xfer(input logic [2:0] sel, input bit rd, input int n,
                          input logic [55:0] w);
    exp_cmd(0, 8'h00, 1'b0);
    exp_cmd(1, {4'b0110, sel, rd}, 1'b0);
    for (int i = 0; i < n; i++) begin
      if (rd) exp_cmd(2, 8'h00, (i == n - 1));
      else    exp_cmd(1, mir(w[55-8*i -: 8]), 1'b0);
    end
    exp_cmd(3, 8'h00, 1'b0);
  endtask

  // behavioural bus master and chip register file, compared on every command
  always @(negedge clk) begin
    if (!rst_n) begin
      cmd_done = 1'b0; cmd_ack = 1'b0; cmd_err = 1'b0; cmd_rdata = 8'h00;
      mbusy = 1'b0; mcnt = 0;
    end else begin
      if (cmd_done) begin
        cmd_done = 1'b0; cmd_err = 1'b0; mbusy = 1'b0;
      end
      if (!mbusy && cmd_valid) begin
        mk = cmd_kind; md = cmd_wdata; mn = cmd_nack; mbusy = 1'b1; mcnt = 2;
      end else if (mbusy) begin
        if (mcnt > 0) mcnt--;
        else begin
          bit flt, a;
          logic [7:0] rdv;
          flt = (cmd_no == fault_at);
          a = 1'b1;
          rdv = 8'h00;
          if (qk.size() == 0) chk(1'b0, "R11", "unexpected command", 64'(mk), 64'hF);
          else begin
            int ek; logic [7:0] ed; bit en;
            ek = qk.pop_front(); ed = qd.pop_front(); en = qn.pop_front();
            chk(int'(mk) == ek, "R11", "command kind", 64'(mk), 64'(ek));
            if (ek == 1 && int'(mk) == 1) chk(md == ed, "R2", "written byte (R1 address)", 64'(md), 64'(ed));
            if (ek == 2 && int'(mk) == 2) chk(mn == en, "R9", "read nack flag", 64'(mn), 64'(en));
          end
          case (mk)
            2'd0: cidx = -1;
            2'd1: if (cidx < 0) begin
                    csel = md[3:1];
                    a = (md[7:4] == 4'b0110);
                    cidx = 0;
                  end else begin
                    if (!flt && cidx < 7) mem[csel][cidx] = md;
                    cidx++;
                  end
            2'd2: begin
                    if (cidx >= 0 && cidx < 7) rdv = mem[csel][cidx];
                    cidx++;
                  end
            default: ;
          endcase
          if (flt) begin
            if (fault_err) cmd_err = 1'b1;
            else a = 1'b0;
          end
          cmd_ack = a;
          cmd_rdata = rdv;
          cmd_done = 1'b1;
          cmd_no++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && host_ack && !ack_allowed)
      chk(1'b0, "R5", "host_ack without accepted request", 64'(host_ack), 64'h0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, 150000);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  task automatic do_reset(input logic [7:0] s1, input logic [7:0] s2,
                          input int flt, input bit ferr);
    rst_n = 1'b0;
    host_req = 1'b0; host_op = 1'b0; host_wtime = '0; ack_allowed = 1'b0;
    fault_at = flt; fault_err = ferr;
    mem[0][0] = mir(s1);
    mem[1][0] = mir(s2);
    qk.delete(); qd.delete(); qn.delete();
    repeat (3) @(negedge clk);
    cmd_no = 0;
    chk(busy == 1'b1 && ready == 1'b0 && init_fail == 1'b0, "R5", "reset flags",
        {61'b0, busy, ready, init_fail}, 64'h4);
    chk(cmd_valid == 1'b0 && host_ack == 1'b0, "R11", "reset bus idle",
        {62'b0, cmd_valid, host_ack}, 64'h0);
    rst_n = 1'b1;
  endtask

  task automatic wait_init();
    int n = 0;
    while (!ready && !init_fail && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) chk(1'b0, "R5", "init timeout", 64'(n), 64'h0);
  endtask

  task automatic host_xfer(input bit op, input logic [55:0] w,
                           output bit err, output logic [55:0] r);
    int n = 0;
    @(negedge clk);
    host_op = op; host_wtime = w; host_req = 1'b1; ack_allowed = 1'b1;
    @(negedge clk);
    while (!host_ack && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) chk(1'b0, "R12", "host_ack timeout", 64'(n), 64'h0);
    err = host_err; r = host_rtime;
    host_req = 1'b0;
    @(negedge clk);
    chk(host_ack == 1'b0, "R12", "ack pulse width", 64'(host_ack), 64'h0);
    ack_allowed = 1'b0;
  endtask

  task automatic chk_drained(input string rq);
    chk(qk.size() == 0, rq, "expected commands left", 64'(qk.size()), 64'h0);
  endtask

  initial begin
    bit e;
    logic [55:0] r;
    for (int s = 0; s < 8; s++) for (int b = 0; b < 7; b++) mem[s][b] = 8'h00;
    cmd_no = 0; cidx = -1; csel = '0;

    // A: both repairs, set requested before ready, then read back
    do_reset(8'h80, 8'h81, -1, 1'b0);
    exp_xfer(3'd0, 1'b1, 1, '0);
    exp_xfer(3'd0, 1'b0, 1, {8'h83, 48'h0});
    exp_xfer(3'd1, 1'b1, 1, '0);
    exp_xfer(3'd1, 1'b0, 1, {8'h01, 48'h0});
    exp_xfer(3'd2, 1'b0, 7, T1);
    host_op = 1'b1; host_wtime = T1; host_req = 1'b1;
    wait_init();
    chk(ready == 1'b1, "R5", "ready after bring-up", 64'(ready), 64'h1);
    ack_allowed = 1'b1;
    begin
      int n = 0;
      while (!host_ack && n < 3000) begin @(negedge clk); n++; end
    end
    chk(host_err == 1'b0, "R8", "set status", 64'(host_err), 64'h0);
    host_req = 1'b0;
    @(negedge clk);
    ack_allowed = 1'b0;
    chk(mem[0][0] == mir(8'h83), "R3", "status1 after repair", 64'(mem[0][0]), 64'(mir(8'h83)));
    chk(mem[1][0] == mir(8'h01), "R4", "status2 test bit cleared", 64'(mem[1][0]), 64'(mir(8'h01)));
    for (int b = 0; b < 7; b++)
      chk(mem[2][b] == mir(T1[55-8*b -: 8]), "R8", "calendar byte stored", 64'(mem[2][b]), 64'(mir(T1[55-8*b -: 8])));
    exp_xfer(3'd2, 1'b1, 7, '0);
    host_xfer(1'b0, '0, e, r);
    chk(e == 1'b0, "R6", "get status", 64'(e), 64'h0);
    chk(r == (T1 & MASKB), "R7", "get masked time", r, T1 & MASKB);
    chk_drained("R6");

    // B: battery flag only, no test mode
    do_reset(8'h40, 8'h00, -1, 1'b0);
    exp_xfer(3'd0, 1'b1, 1, '0);
    exp_xfer(3'd0, 1'b0, 1, {8'h43, 48'h0});
    exp_xfer(3'd1, 1'b1, 1, '0);
    wait_init();
    chk(ready == 1'b1 && init_fail == 1'b0, "R5", "ready after bring-up", {62'b0, ready, init_fail}, 64'h2);
    chk(mem[0][0] == mir(8'h43), "R3", "status1 from battery flag", 64'(mem[0][0]), 64'(mir(8'h43)));
    chk_drained("R4");

    // C: no repairs, then aborted get, aborted set, clean get
    do_reset(8'h02, 8'h7F, -1, 1'b0);
    for (int b = 0; b < 7; b++) mem[2][b] = mir(T1[55-8*b -: 8]);
    exp_xfer(3'd0, 1'b1, 1, '0);
    exp_xfer(3'd1, 1'b1, 1, '0);
    wait_init();
    chk(mem[0][0] == mir(8'h02), "R3", "status1 untouched", 64'(mem[0][0]), 64'(mir(8'h02)));
    chk_drained("R4");

    fault_at = cmd_no + 4; fault_err = 1'b1;
    exp_cmd(0, 8'h00, 1'b0); exp_cmd(1, 8'h65, 1'b0);
    exp_cmd(2, 8'h00, 1'b0); exp_cmd(2, 8'h00, 1'b0); exp_cmd(2, 8'h00, 1'b0);
    exp_cmd(3, 8'h00, 1'b0);
    host_xfer(1'b0, '0, e, r);
    chk(e == 1'b1, "R10", "get bus error", 64'(e), 64'h1);
    chk_drained("R10");

    fault_at = cmd_no + 3; fault_err = 1'b0;
    exp_cmd(0, 8'h00, 1'b0); exp_cmd(1, 8'h64, 1'b0);
    exp_cmd(1, mir(8'h99), 1'b0); exp_cmd(1, mir(8'h88), 1'b0);
    exp_cmd(3, 8'h00, 1'b0);
    host_xfer(1'b1, T2, e, r);
    chk(e == 1'b1, "R10", "set missing ack", 64'(e), 64'h1);
    chk_drained("R10");
    fault_at = -1;

    exp_xfer(3'd2, 1'b1, 7, '0);
    host_xfer(1'b0, '0, e, r);
    chk(e == 1'b0, "R6", "get after errors", 64'(e), 64'h0);
    chk(r == ({8'h99, T1[47:0]} & MASKB), "R10", "only bytes before abort written",
        r, {8'h99, T1[47:0]} & MASKB);

    // D: address not acknowledged on first status read
    do_reset(8'h80, 8'h00, 1, 1'b0);
    exp_cmd(0, 8'h00, 1'b0); exp_cmd(1, 8'h61, 1'b0); exp_cmd(3, 8'h00, 1'b0);
    wait_init();
    chk(init_fail == 1'b1 && ready == 1'b0, "R10", "bring-up abort", {62'b0, init_fail, ready}, 64'h2);
    host_op = 1'b0; host_req = 1'b1;
    repeat (40) @(negedge clk);
    chk(busy == 1'b1 && host_ack == 1'b0, "R5", "request refused after failure", {62'b0, busy, host_ack}, 64'h2);
    host_req = 1'b0;
    chk_drained("R10");

    // E: status1 repair write not acknowledged
    do_reset(8'h80, 8'h80, 6, 1'b0);
    exp_xfer(3'd0, 1'b1, 1, '0);
    exp_cmd(0, 8'h00, 1'b0); exp_cmd(1, 8'h60, 1'b0);
    exp_cmd(1, mir(8'h83), 1'b0); exp_cmd(3, 8'h00, 1'b0);
    wait_init();
    repeat (20) @(negedge clk);
    chk(init_fail == 1'b1, "R10", "abort on data nack", 64'(init_fail), 64'h1);
    chk(mem[0][0] == mir(8'h80), "R10", "status1 not modified", 64'(mem[0][0]), 64'(mir(8'h80)));
    chk_drained("R10");

    // F: bus error on the start of the status2 read
    do_reset(8'h00, 8'h80, 4, 1'b1);
    exp_xfer(3'd0, 1'b1, 1, '0);
    exp_cmd(0, 8'h00, 1'b0); exp_cmd(3, 8'h00, 1'b0);
    wait_init();
    repeat (20) @(negedge clk);
    chk(init_fail == 1'b1 && ready == 1'b0, "R10", "abort on start error", {62'b0, init_fail, ready}, 64'h2);
    chk(mem[1][0] == mir(8'h80), "R4", "status2 not modified", 64'(mem[1][0]), 64'(mir(8'h80)));
    chk_drained("R10");

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule